// File: doc/BRIEF.md
# Block Memory Move Engine

The engine copies a run of bytes from one memory region to another, one byte per transfer. It holds three working registers: a source pointer, a destination pointer and a remaining-count register. The count register is loaded with the block length minus one. A direction input chooses between two modes. In ascending mode both pointers count up. In descending mode both pointers count down. Software picks the mode that suits the overlap, so that an overlapping block is never read after it has been overwritten.

Each pointer is extended to a 24-bit address by an 8-bit bank value that is captured when the move starts. Memory is reached through a single synchronous port with a request line, a write enable and a ready handshake. Every byte takes a read cycle, a write cycle and a register-update cycle. When the move ends, the final pointer and count values stay visible at the outputs, and a one-cycle done pulse is raised.

Top module: `blk_move_engine`

## Requirements
- R1: After reset, busy, done and mem_req are 0. A start pulse while idle loads the source pointer, destination pointer and count from their inputs, and latches the direction and both bank bytes. On the next cycle busy is 1 and x_out shows the loaded source pointer.
- R2: In ascending mode (dir_desc=0), each byte is read from {src bank, X} and written to {dst bank, Y}. Afterwards X and Y are incremented and the count is decremented.
- R3: In descending mode (dir_desc=1), each byte is handled the same way, and then X, Y and the count are all decremented.
- R4: The move ends in the update cycle where the count wraps from 0x0000 to 0xFFFF, so a loaded count of C moves C+1 bytes. The example of 0x0800 to 0x0912 with count 0x0047, ascending, ends with X=0x0848, Y=0x095A and count 0xFFFF.
- R5: A loaded count of 0x0000 moves exactly one byte. Block sizes from 1 to 65536 bytes are representable.
- R6: Bits 23:16 of mem_addr always carry the latched source bank on reads and the latched destination bank on writes. Pointer stepping wraps within 16 bits (0xFFFF+1 gives 0x0000) and never changes the bank.
- R7: When mem_ready stays high, each byte costs exactly 3 clock cycles. No memory access is made in the update cycle.
- R8: While mem_req is high and mem_ready is low, the engine holds its state, and mem_addr and mem_we stay unchanged on the next cycle.
- R9: done is high for exactly one cycle, in the first idle cycle after the final update. busy is 0 whenever done is 1.
- R10: A start pulse while busy is ignored. The move finishes with the results of the original operands, and no new move begins afterwards.
- R11: The byte written for each transfer equals the byte read in that transfer's read cycle, so the destination region ends as a correct copy, including overlapping copies done in the matching direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, honoured only when idle |
| dir_desc | input | 1 | 0 = ascending, 1 = descending |
| src_bank | input | 8 | Source bank byte (address bits 23:16) |
| dst_bank | input | 8 | Destination bank byte (address bits 23:16) |
| src_ptr_in | input | 16 | Initial source pointer |
| dst_ptr_in | input | 16 | Initial destination pointer |
| count_in | input | 16 | Byte count minus one |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled when mem_req, read and mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| x_out | output | 16 | Current source pointer |
| y_out | output | 16 | Current destination pointer |
| c_out | output | 16 | Current count register |

## Verification
A start sampled at a clock edge makes busy and the loaded pointers visible after that edge. With mem_ready held high, done appears 3N edges later for an N-byte move, so the bench expects it on the (3N+1)-th falling-edge sample after driving start. In runs with random ready stalls, only completion is awaited, and the final registers and memory contents are compared with a reference copy computed in the bench. Bank bytes are checked on every completed access, and the done pulse is checked to have fallen again one sample later.

// File: rtl/bme_pkg.sv
package bme_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_READ   = 2'd1,
      PH_WRITE  = 2'd2,
      PH_UPDATE = 2'd3
   } phase_t;
endpackage

// File: rtl/bme_ctrl.sv
module bme_ctrl
   import bme_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   mem_ready,
   input  logic   last,
   output phase_t phase,
   output logic   load,
   output logic   step,
   output logic   capture,
   output logic   done
);
   phase_t phase_q, phase_d;
   logic   done_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (start)     phase_d = PH_READ;
         PH_READ:   if (mem_ready) phase_d = PH_WRITE;
         PH_WRITE:  if (mem_ready) phase_d = PH_UPDATE;
         PH_UPDATE: phase_d = last ? PH_IDLE : PH_READ;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_UPDATE) && last;
      end
   end

   assign phase   = phase_q;
   assign load    = (phase_q == PH_IDLE) && start;
   assign step    = (phase_q == PH_UPDATE);
   assign capture = (phase_q == PH_READ) && mem_ready;
   assign done    = done_q;
endmodule

// File: rtl/bme_pointer.sv
module bme_pointer #(
   parameter int OFF_W      = 16,
   parameter int BANK_W     = 8,
   parameter bit CARRY_BANK = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     step,
   input  logic                     desc,
   input  logic [BANK_W-1:0]        bank_in,
   input  logic [OFF_W-1:0]         off_in,
   output logic [BANK_W+OFF_W-1:0]  addr,
   output logic [OFF_W-1:0]         off_out
);
   localparam int FULL_W = BANK_W + OFF_W;

   logic [BANK_W-1:0] bank_q, bank_d;
   logic [OFF_W-1:0]  off_q, off_d;

   generate
      if (CARRY_BANK) begin : g_carry
         logic [FULL_W-1:0] full_nxt;
         always_comb begin
            full_nxt = desc ? ({bank_q, off_q} - FULL_W'(1))
                            : ({bank_q, off_q} + FULL_W'(1));
            bank_d   = full_nxt[FULL_W-1:OFF_W];
            off_d    = full_nxt[OFF_W-1:0];
         end
      end else begin : g_wrap
         always_comb begin
            bank_d = bank_q;
            off_d  = desc ? (off_q - OFF_W'(1)) : (off_q + OFF_W'(1));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         off_q  <= '0;
      end else if (load) begin
         bank_q <= bank_in;
         off_q  <= off_in;
      end else if (step) begin
         bank_q <= bank_d;
         off_q  <= off_d;
      end
   end

   assign addr    = {bank_q, off_q};
   assign off_out = off_q;
endmodule

// File: rtl/bme_counter.sv
module bme_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] val_in,
   output logic [W-1:0] val_out,
   output logic         last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= val_in;
      else if (step)  cnt_q <= cnt_q - W'(1);
   end

   assign val_out = cnt_q;
   assign last    = (cnt_q == '0);
endmodule

// File: rtl/blk_move_engine.sv
module blk_move_engine
   import bme_pkg::*;
#(
   parameter int OFF_W      = 16,
   parameter int BANK_W     = 8,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 16,
   parameter bit CARRY_BANK = 1'b0,
   localparam int ADDR_W    = OFF_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_desc,
   input  logic [BANK_W-1:0] src_bank,
   input  logic [BANK_W-1:0] dst_bank,
   input  logic [OFF_W-1:0]  src_ptr_in,
   input  logic [OFF_W-1:0]  dst_ptr_in,
   input  logic [CNT_W-1:0]  count_in,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [OFF_W-1:0]  x_out,
   output logic [OFF_W-1:0]  y_out,
   output logic [CNT_W-1:0]  c_out
);
   generate
      if (OFF_W < 2 || BANK_W < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("blk_move_engine: widths must be positive, OFF_W at least 2");
      end
      if (CNT_W > 32) begin : g_bad_count
         $error("blk_move_engine: CNT_W above 32 is not supported");
      end
   endgenerate

   phase_t            phase;
   logic              load, step, capture, last;
   logic              desc_q;
   logic [DATA_W-1:0] hold_q;
   logic [ADDR_W-1:0] src_addr, dst_addr;

   bme_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mem_ready (mem_ready),
      .last      (last),
      .phase     (phase),
      .load      (load),
      .step      (step),
      .capture   (capture),
      .done      (done)
   );

   bme_pointer #(.OFF_W(OFF_W), .BANK_W(BANK_W), .CARRY_BANK(CARRY_BANK)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .desc    (desc_q),
      .bank_in (src_bank),
      .off_in  (src_ptr_in),
      .addr    (src_addr),
      .off_out (x_out)
   );

   bme_pointer #(.OFF_W(OFF_W), .BANK_W(BANK_W), .CARRY_BANK(CARRY_BANK)) u_dst (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .desc    (desc_q),
      .bank_in (dst_bank),
      .off_in  (dst_ptr_in),
      .addr    (dst_addr),
      .off_out (y_out)
   );

   bme_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .val_in  (count_in),
      .val_out (c_out),
      .last    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_q <= 1'b0;
         hold_q <= '0;
      end else begin
         if (load)    desc_q <= dir_desc;
         if (capture) hold_q <= mem_rdata;
      end
   end

   assign busy      = (phase != PH_IDLE);
   assign mem_req   = (phase == PH_READ) || (phase == PH_WRITE);
   assign mem_we    = (phase == PH_WRITE);
   assign mem_addr  = (phase == PH_WRITE) ? dst_addr : src_addr;
   assign mem_wdata = hold_q;
endmodule

// File: rtl/bme_checker.sv
module bme_checker #(
   parameter int OFF_W  = 16,
   parameter int BANK_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    busy,
   input logic                    done,
   input logic                    mem_req,
   input logic                    mem_we,
   input logic                    mem_ready,
   input logic [BANK_W+OFF_W-1:0] mem_addr,
   input logic [BANK_W-1:0]       src_bank,
   input logic [BANK_W-1:0]       dst_bank
);
   localparam int AW = BANK_W + OFF_W;
   logic [BANK_W-1:0] sb_q, db_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_q <= '0;
         db_q <= '0;
      end else if (start && !busy) begin
         sb_q <= src_bank;
         db_q <= dst_bank;
      end
   end

   // R1: an accepted start makes the engine busy
   assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R6: bank bytes on the address bus
   assert_src_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_addr[AW-1:OFF_W] == sb_q);
   assert_dst_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr[AW-1:OFF_W] == db_q);

   // R7: the cycle after a completed write is an access-free update cycle
   assert_update_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ready |=> !mem_req);

   // R8: a stalled access holds steady
   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R9: done is a single-cycle pulse while idle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind blk_move_engine bme_checker #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_bme_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .src_bank  (src_bank),
   .dst_bank  (dst_bank)
);

// File: tb/blk_move_engine_bench.sv
module blk_move_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir_desc = 1'b0;
   logic [7:0]  src_bank = '0, dst_bank = '0;
   logic [15:0] src_ptr_in = '0, dst_ptr_in = '0, count_in = '0;
   logic        busy, done, mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;
   logic [15:0] x_out, y_out, c_out;

   logic [7:0]  mem     [4096];
   logic [7:0]  ref_mem [4096];
   logic        stall_en = 1'b0;
   logic [7:0]  exp_sb = '0, exp_db = '0;
   int          bank_err = 0;
   int          n_checks = 0;
   int          n_fail = 0;

   always #4 clk = ~clk;

   blk_move_engine u_blk_move_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_desc(dir_desc),
      .src_bank(src_bank), .dst_bank(dst_bank), .src_ptr_in(src_ptr_in),
      .dst_ptr_in(dst_ptr_in), .count_in(count_in), .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .x_out(x_out), .y_out(y_out), .c_out(c_out)
   );

   assign mem_rdata = mem[mem_addr[11:0]];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (mem_addr[23:16] != exp_db) bank_err <= bank_err + 1;
         end else if (mem_addr[23:16] != exp_sb) begin
            bank_err <= bank_err + 1;
         end
      end
   end

   always @(negedge clk) mem_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] step_ptr(input logic [15:0] p, input int n, input bit d);
      return d ? 16'(p - 16'(n)) : 16'(p + 16'(n));
   endfunction

   task automatic run_move(input logic [15:0] sx, input logic [15:0] dx, input logic [15:0] c,
                           input logic [7:0] sb, input logic [7:0] db, input bit d,
                           input bit stalls, input bit inject);
      int n = int'(c) + 1;
      int cyc = 0;
      int mism = 0;
      for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
      for (int k = 0; k < n; k++) begin
         logic [15:0] sa = step_ptr(sx, k, d);
         logic [15:0] da = step_ptr(dx, k, d);
         ref_mem[da[11:0]] = ref_mem[sa[11:0]];
      end
      exp_sb = sb; exp_db = db; bank_err = 0;
      @(negedge clk);
      stall_en = stalls;
      src_ptr_in = sx; dst_ptr_in = dx; count_in = c;
      src_bank = sb; dst_bank = db; dir_desc = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      src_ptr_in = 16'hDEAD; dst_ptr_in = 16'hBEEF; count_in = 16'h0003;
      src_bank = ~sb; dst_bank = ~db; dir_desc = ~d;
      cyc = 1;
      check(busy === 1'b1, "R1 busy after start", int'(busy), 1);
      check(x_out === sx, "R1 x loaded", int'(x_out), int'(sx));
      while (done !== 1'b1 && cyc < 20000) begin
         if (inject && cyc == 4) start = 1'b1;
         if (inject && cyc == 5) start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(cyc < 20000, "R9 done arrives", cyc, 3 * n + 1);
      if (cyc >= 20000) begin
         stall_en = 1'b0;
         return;
      end
      if (!stalls)
         check(cyc == 3 * n + 1, "R7 three cycles per byte", cyc, 3 * n + 1);
      check(busy === 1'b0, "R9 idle with done", int'(busy), 0);
      check(x_out === step_ptr(sx, n, d), d ? "R3 final X" : "R2 final X",
            int'(x_out), int'(step_ptr(sx, n, d)));
      check(y_out === step_ptr(dx, n, d), d ? "R3 final Y" : "R2 final Y",
            int'(y_out), int'(step_ptr(dx, n, d)));
      check(c_out === 16'hFFFF, "R4 count wraps", int'(c_out), 16'hFFFF);
      check(bank_err == 0, "R6 bank bytes", bank_err, 0);
      for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
      check(mism == 0, "R11 copied bytes", mism, 0);
      @(negedge clk);
      check(done === 1'b0, "R9 done one cycle", int'(done), 0);
      if (inject) check(busy === 1'b0, "R10 no restart", int'(busy), 0);
      stall_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 reset state",
            int'({busy, done, mem_req}), 0);

      // R4 / R2: the documented ascending example
      run_move(16'h0800, 16'h0912, 16'h0047, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      check(x_out === 16'h0848 && y_out === 16'h095A, "R4 example pointers",
            int'({x_out, y_out}), 32'h0848095A);
      // R5: single byte, descending
      run_move(16'h0400, 16'h0500, 16'h0000, 8'h01, 8'h02, 1'b1, 1'b0, 1'b0);
      // R6: pointer wrap within 16 bits with non-zero banks
      run_move(16'hFFFE, 16'h0100, 16'h0003, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
      run_move(16'h0001, 16'hFFFF, 16'h0002, 8'hA5, 8'h5A, 1'b1, 1'b0, 1'b0);
      // R11: overlapping copy upward done descending
      run_move(16'h0220, 16'h0222, 16'h0010, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      // R11: overlapping copy downward done ascending
      run_move(16'h0300, 16'h02FD, 16'h0010, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      // R10: start while busy, R8: stalls
      run_move(16'h0600, 16'h0700, 16'h0020, 8'h07, 8'h09, 1'b0, 1'b0, 1'b1);
      run_move(16'h0640, 16'h0740, 16'h0018, 8'h03, 8'h04, 1'b1, 1'b1, 1'b1);
      // random mix
      for (int t = 0; t < 24; t++) begin
         run_move(16'($urandom), 16'($urandom), 16'($urandom % 48), 8'($urandom),
                  8'($urandom), 1'($urandom), 1'(t % 2), 1'b0);
      end
      // R5: larger block
      run_move(16'h0000, 16'h0800, 16'h012B, 8'h10, 8'h20, 1'b0, 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule